// File: doc/BRIEF.md
# Endpoint Bank Controller

This block keeps the bookkeeping for a small ring of data banks that belong to one device-side endpoint of a serial bus. It knows which banks hold data, which bank software is working on, and which bank the bus engine uses next. Software hands a bank back by clearing the bank-control bit, and the block then moves to the next bank. The bus engine reports an arriving IN token, a transmitted packet, or a received packet. The packet serializer, the bank storage and the protocol are not part of this block.

One parameter sets the endpoint direction: 0 for control, 1 for IN, 2 for OUT. A second parameter sets the bank count, from one to three. On IN endpoints, software can ask for the most recently committed bank to be discarded. That request is weighed against any transmission that is in progress. Three status flags feed one interrupt output, each through its own enable bit. Each enable bit has a set strobe and a clear strobe. There is no direct write.

Top module: `ep_bank_ctrl`

## Requirements
- R1: A synchronous active-low reset empties all banks. After reset the busy count, both bank indices, the bank-control bit, the kill-pending bit, all flags, all enables and the interrupt are zero.
- R2: A pulse on `ie_set[i]` turns enable i on from the next cycle. A pulse on `ie_clr[i]` turns it off. When both pulse in the same cycle, the clear wins.
- R3: Flag bit 0 means a bank is ready for software. Flag bit 1 means the busy count changed. Flag bit 2 means a kill finished. `flag_clr[i]` clears flag i, but a new event in the same cycle wins. `irq` is high exactly when some flag is set together with its enable.
- R4: IN endpoint, when the busy count is below the bank count and `fifo_ctl` is low: in the next cycle `fifo_ctl` and flag 0 rise together. A `fifo_rel` pulse while `fifo_ctl` is high commits the bank. `fifo_ctl` falls, the busy count goes up by one, and `sw_bank` advances modulo the bank count.
- R5: OUT endpoint: `pkt_rcvd` fills the bank at `bus_bank` and raises the busy count, unless all banks are already busy, in which case it is ignored. While at least one bank is busy and `fifo_ctl` is low, `fifo_ctl` and flag 0 rise together in the next cycle. `fifo_rel` frees the bank at `sw_bank`.
- R6: Control endpoint: `fifo_ctl` and `rw_allowed` always read 0 and the busy count stays 0. `pkt_rcvd` or `pkt_sent` sets flag 0.
- R7: The busy count never exceeds the bank count. On IN it drops by one on `pkt_sent`, and `bus_bank` advances. Flag 1 is set in the cycle the count changes.
- R8: On an IN endpoint, a `kill_set` pulse makes `kill_busy` high from the next cycle. `kill_busy` stays high until the kill procedure ends. A `kill_set` while `kill_busy` is high, or on any other endpoint type, has no effect.
- R9: With two or more banks busy, a pending kill succeeds even if an IN token arrives in the same cycle. The busy count drops by one, `sw_bank` steps back to the discarded bank, `kill_busy` falls and flag 2 is set.
- R10: With exactly one bank busy, a pending kill is refused while that bank is being transmitted. That is the case from an IN token up to and including the `pkt_sent` cycle. The kill stays pending and the busy count is unchanged by it.
- R11: A pending kill that finds no busy bank ends in one cycle without discarding anything. The busy count and flag 1 are unchanged, and flag 2 is set.
- R12: On IN and OUT endpoints `rw_allowed` equals `fifo_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ie_set | input | 3 | Per-flag enable set strobes |
| ie_clr | input | 3 | Per-flag enable clear strobes |
| flag_clr | input | 3 | Per-flag clear strobes |
| fifo_rel | input | 1 | Software release of the current bank |
| kill_set | input | 1 | Software request to discard the last committed bank |
| in_token | input | 1 | Bus engine: IN token arrived |
| pkt_sent | input | 1 | Bus engine: packet transmitted |
| pkt_rcvd | input | 1 | Bus engine: packet received |
| fifo_ctl | output | 1 | Bank-control bit (current bank handed to software) |
| rw_allowed | output | 1 | Software may access the current bank |
| kill_busy | output | 1 | Kill procedure pending |
| busy_cnt | output | CNT_W | Number of busy banks |
| sw_bank | output | PTR_W | Bank index used by software |
| bus_bank | output | PTR_W | Bank index used by the bus engine |
| ie | output | 3 | Interrupt enables |
| flags | output | 3 | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds three instances. The first is an IN endpoint with two banks. It covers both sides of the kill arbitration, the full-ring stall of the bank-control bit and pointer wrap-around. The second is an OUT endpoint with three banks. It covers filling every bank, a receive that is ignored when all banks are busy, and a pointer width above one bit. The third is a single-bank control endpoint, which shows that the bank-control bits stay at zero and that kill requests are ignored outside IN.

// File: rtl/ep_bank_pkg.sv
// Shared types and constants for the endpoint bank controller.
// Assumes: flag positions are fixed and decoded by software.
package ep_bank_pkg;

    // Endpoint direction; numeric codes are part of the parameter contract.
    typedef enum logic [1:0] {
        EPD_CTRL = 2'd0,
        EPD_IN   = 2'd1,
        EPD_OUT  = 2'd2
    } ep_dir_e;

    localparam int NFLAG    = 3;
    localparam int FLG_XFER = 0;
    localparam int FLG_BUSY = 1;
    localparam int FLG_KILL = 2;

endpackage

// File: rtl/ep_bank_ring.sv
// Ring of bank indices: a tail pointer (next bank to be filled or
// committed), a head pointer (oldest busy bank) and the busy count.
// Assumes: the caller never pushes when full, never pops or drops when
// empty, and never pushes and drops in the same cycle.
module ep_bank_ring #(
    parameter int NUM_BANKS = 2,
    parameter int PTR_W     = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             drop,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BANKS - 1);

    function automatic logic [PTR_W-1:0] step_fwd(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] step_back(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - PTR_W'(1);
    endfunction

    // Occupancy after this cycle's events.
    always_comb begin
        count_nxt = count + CNT_W'(push) - CNT_W'(pop) - CNT_W'(drop);
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail  <= '0;
            head  <= '0;
            count <= '0;
        end else begin
            count <= count_nxt;
            if (push) begin
                tail <= step_fwd(tail);
            end else if (drop) begin
                tail <= step_back(tail);
            end
            if (pop) begin
                head <= step_fwd(head);
            end
        end
    end

endmodule

// File: rtl/ep_kill_ctl.sv
// Kill-last-bank sequencer. Holds a pending request and, each cycle it is
// not held off, either discards the newest busy bank, refuses because the
// only busy bank is on the wire, or finishes empty-handed.
// Assumes: in_busy covers the token cycle through the sent cycle.
module ep_kill_ctl #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             kill_req,
    input  logic             hold,
    input  logic             in_busy,
    input  logic [CNT_W-1:0] count,
    output logic             pending,
    output logic             drop,
    output logic             done
);

    logic attempt;
    logic empty;
    logic multi;

    // Arbitration between the pending kill and the bus side.
    always_comb begin
        attempt = pending && !hold;
        empty   = (count == '0);
        multi   = (count > CNT_W'(1));
        drop    = attempt && !empty && (multi || !in_busy);
        done    = attempt && (empty || drop);
    end

    // Pending flag: set by request, cleared only when the procedure ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (done) begin
            pending <= 1'b0;
        end else if (kill_req && enable) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/ep_irq_regs.sv
// Interrupt enables (set/clear strobes only), sticky status flags and the
// gated interrupt output.
// Assumes: flag events win over flag clears, enable clears win over sets.
module ep_irq_regs #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] ie_set,
    input  logic [NFLAG-1:0] ie_clr,
    input  logic [NFLAG-1:0] flag_set,
    input  logic [NFLAG-1:0] flag_clr,
    output logic [NFLAG-1:0] ie,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);

    // Enable and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie    <= '0;
            flags <= '0;
        end else begin
            ie    <= (ie | ie_set) & ~ie_clr;
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    // Interrupt request from enabled flags.
    always_comb begin
        irq = |(flags & ie);
    end

endmodule

// File: rtl/ep_bank_ctrl.sv
// Bank controller for one endpoint. Maps software and bus events onto the
// bank ring according to the endpoint direction, drives the bank-control
// bit and feeds the flag/interrupt registers.
// Assumes: event strobes are single-cycle; software respects kill_busy.
module ep_bank_ctrl
    import ep_bank_pkg::*;
#(
    parameter int      NUM_BANKS = 2,
    parameter ep_dir_e EP_DIR    = EPD_IN,
    localparam int     PTR_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int     CNT_W     = $clog2(NUM_BANKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] ie_set,
    input  logic [NFLAG-1:0] ie_clr,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic             fifo_rel,
    input  logic             kill_set,
    input  logic             in_token,
    input  logic             pkt_sent,
    input  logic             pkt_rcvd,
    output logic             fifo_ctl,
    output logic             rw_allowed,
    output logic             kill_busy,
    output logic [CNT_W-1:0] busy_cnt,
    output logic [PTR_W-1:0] sw_bank,
    output logic [PTR_W-1:0] bus_bank,
    output logic [NFLAG-1:0] ie,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BANKS);

    logic             fifo_q;
    logic             release_ok;
    logic             push, pop, kill_drop, kill_done;
    logic             kill_en, in_busy;
    logic             fifo_set, xfer_evt;
    logic             bus_evt;
    logic [PTR_W-1:0] tail, head;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [NFLAG-1:0] flag_set;

    // Software release is only meaningful while the bank is handed over.
    always_comb begin
        release_ok = fifo_rel && fifo_q;
        bus_evt    = (EP_DIR == EPD_OUT) ? pkt_rcvd : pkt_sent;
    end

    generate
        if (EP_DIR == EPD_IN) begin : g_in
            logic tx_active;

            // Track a transmission from IN token to packet sent.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tx_active <= 1'b0;
                end else if (pkt_sent) begin
                    tx_active <= 1'b0;
                end else if (in_token && (cnt != '0)) begin
                    tx_active <= 1'b1;
                end
            end

            // IN mapping: software commits, bus drains, kill trims the tail.
            always_comb begin
                push     = release_ok;
                pop      = bus_evt && (cnt != '0);
                kill_en  = 1'b1;
                in_busy  = in_token || tx_active || pkt_sent;
                fifo_set = !fifo_q && (cnt < FULL);
                xfer_evt = fifo_set;
            end
            assign sw_bank  = tail;
            assign bus_bank = head;
        end else if (EP_DIR == EPD_OUT) begin : g_out
            // OUT mapping: bus fills, software drains.
            always_comb begin
                push     = bus_evt && (cnt < FULL);
                pop      = release_ok;
                kill_en  = 1'b0;
                in_busy  = 1'b0;
                fifo_set = !fifo_q && (cnt != '0);
                xfer_evt = fifo_set;
            end
            assign sw_bank  = head;
            assign bus_bank = tail;
        end else begin : g_ctrl
            // Control mapping: no bank rotation, flag on any bus packet.
            always_comb begin
                push     = 1'b0;
                pop      = 1'b0;
                kill_en  = 1'b0;
                in_busy  = 1'b0;
                fifo_set = 1'b0;
                xfer_evt = bus_evt || pkt_rcvd;
            end
            assign sw_bank  = '0;
            assign bus_bank = '0;
        end
    endgenerate

    ep_bank_ring #(
        .NUM_BANKS(NUM_BANKS),
        .PTR_W    (PTR_W),
        .CNT_W    (CNT_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .drop     (kill_drop),
        .tail     (tail),
        .head     (head),
        .count    (cnt),
        .count_nxt(cnt_nxt)
    );

    ep_kill_ctl #(
        .CNT_W(CNT_W)
    ) u_kill (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (kill_en),
        .kill_req(kill_set),
        .hold    (release_ok),
        .in_busy (in_busy),
        .count   (cnt),
        .pending (kill_busy),
        .drop    (kill_drop),
        .done    (kill_done)
    );

    // Bank-control bit: raised by hardware, lowered by software release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= 1'b0;
        end else if (fifo_set) begin
            fifo_q <= 1'b1;
        end else if (release_ok) begin
            fifo_q <= 1'b0;
        end
    end

    // Flag events collected at their bit positions.
    always_comb begin
        flag_set           = '0;
        flag_set[FLG_XFER] = xfer_evt;
        flag_set[FLG_BUSY] = (cnt_nxt != cnt);
        flag_set[FLG_KILL] = kill_done;
    end

    ep_irq_regs #(
        .NFLAG(NFLAG)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie_set  (ie_set),
        .ie_clr  (ie_clr),
        .flag_set(flag_set),
        .flag_clr(flag_clr),
        .ie      (ie),
        .flags   (flags),
        .irq     (irq)
    );

    assign fifo_ctl   = fifo_q;
    assign rw_allowed = fifo_q;
    assign busy_cnt   = cnt;

endmodule

// File: rtl/ep_bank_ctrl_chk.sv
// Property checker for ep_bank_ctrl, attached through bind.
// Assumes: observes only the top-level ports of the controller.
module ep_bank_ctrl_chk
    import ep_bank_pkg::*;
#(
    parameter int      NUM_BANKS = 2,
    parameter ep_dir_e EP_DIR    = EPD_IN,
    localparam int     PTR_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int     CNT_W     = $clog2(NUM_BANKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NFLAG-1:0] ie_clr,
    input logic             fifo_rel,
    input logic             in_token,
    input logic             fifo_ctl,
    input logic             rw_allowed,
    input logic             kill_busy,
    input logic [CNT_W-1:0] busy_cnt,
    input logic [PTR_W-1:0] sw_bank,
    input logic [NFLAG-1:0] ie,
    input logic [NFLAG-1:0] flags
);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(NUM_BANKS));

    p_busy_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != $past(busy_cnt)) |-> flags[FLG_BUSY]);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rel && fifo_ctl) |=> !fifo_ctl);

    p_fifo_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_ctl) |-> flags[FLG_XFER]);

    p_ctrl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (EP_DIR == EPD_CTRL) |-> (!fifo_ctl && !rw_allowed));

    p_ie_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ie_clr) |=> ((ie & $past(ie_clr)) == '0));

    p_kill_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_busy && in_token && busy_cnt == CNT_W'(1)) |=> kill_busy);

    p_kill_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_busy && busy_cnt == '0 && !(fifo_rel && fifo_ctl))
        |=> (!kill_busy && flags[FLG_KILL] && busy_cnt == '0));

    p_sw_bank_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sw_bank) < NUM_BANKS);

endmodule

bind ep_bank_ctrl ep_bank_ctrl_chk #(
    .NUM_BANKS(NUM_BANKS),
    .EP_DIR   (EP_DIR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ie_clr    (ie_clr),
    .fifo_rel  (fifo_rel),
    .in_token  (in_token),
    .fifo_ctl  (fifo_ctl),
    .rw_allowed(rw_allowed),
    .kill_busy (kill_busy),
    .busy_cnt  (busy_cnt),
    .sw_bank   (sw_bank),
    .ie        (ie),
    .flags     (flags)
);

// File: tb/tb_ep_bank_ctrl.sv
`timescale 1ns/1ps
module tb_ep_bank_ctrl;
    import ep_bank_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ie_set = '0, ie_clr = '0, flag_clr = '0;
    logic       fifo_rel = 1'b0, kill_set = 1'b0;
    logic       in_token = 1'b0, pkt_sent = 1'b0, pkt_rcvd = 1'b0;

    // IN instance, two banks
    logic       i_fifo, i_rw, i_kill, i_irq;
    logic [1:0] i_cnt;
    logic [0:0] i_sw, i_bus;
    logic [2:0] i_ie, i_flags;
    // OUT instance, three banks
    logic       o_fifo, o_rw, o_kill, o_irq;
    logic [1:0] o_cnt, o_sw, o_bus;
    logic [2:0] o_ie, o_flags;
    // Control instance, one bank
    logic       c_fifo, c_rw, c_kill, c_irq;
    logic [0:0] c_cnt, c_sw, c_bus;
    logic [2:0] c_ie, c_flags;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ep_bank_ctrl #(.NUM_BANKS(2), .EP_DIR(EPD_IN)) dut (
        .clk(clk), .rst_n(rst_n), .ie_set(ie_set), .ie_clr(ie_clr),
        .flag_clr(flag_clr), .fifo_rel(fifo_rel), .kill_set(kill_set),
        .in_token(in_token), .pkt_sent(pkt_sent), .pkt_rcvd(pkt_rcvd),
        .fifo_ctl(i_fifo), .rw_allowed(i_rw), .kill_busy(i_kill),
        .busy_cnt(i_cnt), .sw_bank(i_sw), .bus_bank(i_bus), .ie(i_ie),
        .flags(i_flags), .irq(i_irq));

    ep_bank_ctrl #(.NUM_BANKS(3), .EP_DIR(EPD_OUT)) dut_o (
        .clk(clk), .rst_n(rst_n), .ie_set(ie_set), .ie_clr(ie_clr),
        .flag_clr(flag_clr), .fifo_rel(fifo_rel), .kill_set(kill_set),
        .in_token(in_token), .pkt_sent(pkt_sent), .pkt_rcvd(pkt_rcvd),
        .fifo_ctl(o_fifo), .rw_allowed(o_rw), .kill_busy(o_kill),
        .busy_cnt(o_cnt), .sw_bank(o_sw), .bus_bank(o_bus), .ie(o_ie),
        .flags(o_flags), .irq(o_irq));

    ep_bank_ctrl #(.NUM_BANKS(1), .EP_DIR(EPD_CTRL)) dut_c (
        .clk(clk), .rst_n(rst_n), .ie_set(ie_set), .ie_clr(ie_clr),
        .flag_clr(flag_clr), .fifo_rel(fifo_rel), .kill_set(kill_set),
        .in_token(in_token), .pkt_sent(pkt_sent), .pkt_rcvd(pkt_rcvd),
        .fifo_ctl(c_fifo), .rw_allowed(c_rw), .kill_busy(c_kill),
        .busy_cnt(c_cnt), .sw_bank(c_sw), .bus_bank(c_bus), .ie(c_ie),
        .flags(c_flags), .irq(c_irq));

    task automatic chk(input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // One clock: inputs set before are seen at this edge; sample 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
        ie_set = '0; ie_clr = '0; flag_clr = '0;
        fifo_rel = 1'b0; kill_set = 1'b0;
        in_token = 1'b0; pkt_sent = 1'b0; pkt_rcvd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 fifo_ctl", int'(i_fifo), 0);
        chk("R1 busy_cnt", int'(i_cnt), 0);
        chk("R1 kill_busy", int'(i_kill), 0);
        chk("R1 flags", int'(i_flags), 0);
        chk("R1 ie", int'(i_ie), 0);
        chk("R1 irq", int'(i_irq), 0);
        chk("R1 out banks", int'(o_sw) + int'(o_bus), 0);
    endtask

    task automatic t_in_flow();
        do_reset();
        tick();
        chk("R4 fifo_ctl rises", int'(i_fifo), 1);
        chk("R4 xfer flag with fifo_ctl", int'(i_flags[0]), 1);
        chk("R12 rw_allowed", int'(i_rw), 1);
        fifo_rel = 1'b1; tick();
        chk("R4 release drops fifo_ctl", int'(i_fifo), 0);
        chk("R4 commit count", int'(i_cnt), 1);
        chk("R4 sw_bank advance", int'(i_sw), 1);
        chk("R7 busy-change flag", int'(i_flags[1]), 1);
        tick();
        chk("R4 fifo_ctl back", int'(i_fifo), 1);
        fifo_rel = 1'b1; tick();
        chk("R4 count full", int'(i_cnt), 2);
        chk("R4 sw_bank wraps", int'(i_sw), 0);
        tick();
        chk("R4 no fifo_ctl when full", int'(i_fifo), 0);
        in_token = 1'b1; tick();
        pkt_sent = 1'b1; tick();
        chk("R7 sent decrements", int'(i_cnt), 1);
        chk("R7 bus_bank advance", int'(i_bus), 1);
        tick();
        chk("R4 fifo_ctl after drain", int'(i_fifo), 1);
    endtask

    task automatic t_irq();
        do_reset();
        tick();
        chk("R3 irq gated off", int'(i_irq), 0);
        ie_set = 3'b001; tick();
        chk("R2 enable set", int'(i_ie), 1);
        chk("R3 irq on", int'(i_irq), 1);
        ie_set = 3'b001; ie_clr = 3'b001; tick();
        chk("R2 clear wins", int'(i_ie), 0);
        chk("R3 irq off", int'(i_irq), 0);
        ie_set = 3'b001; tick();
        flag_clr = 3'b001; tick();
        chk("R3 flag cleared", int'(i_flags[0]), 0);
        chk("R3 irq after flag clear", int'(i_irq), 0);
    endtask

    task automatic t_kill_two();
        do_reset();
        tick();
        fifo_rel = 1'b1; tick();
        tick();
        fifo_rel = 1'b1; tick();
        chk("R9 setup count", int'(i_cnt), 2);
        kill_set = 1'b1; tick();
        chk("R8 kill_busy rises", int'(i_kill), 1);
        chk("R8 kill ignored on OUT", int'(o_kill), 0);
        in_token = 1'b1; tick();
        chk("R9 kill during token", int'(i_kill), 0);
        chk("R9 count after kill", int'(i_cnt), 1);
        chk("R9 sw_bank back", int'(i_sw), 1);
        chk("R9 kill flag", int'(i_flags[2]), 1);
        pkt_sent = 1'b1; tick();
        chk("R9 current bank sent", int'(i_cnt), 0);
    endtask

    task automatic t_kill_refused();
        do_reset();
        tick();
        fifo_rel = 1'b1; tick();
        kill_set = 1'b1; tick();
        chk("R10 pending", int'(i_kill), 1);
        in_token = 1'b1; tick();
        chk("R10 refused keeps pending", int'(i_kill), 1);
        chk("R10 refused keeps count", int'(i_cnt), 1);
        kill_set = 1'b1; tick();
        chk("R10 still refused", int'(i_kill), 1);
        chk("R8 second strobe no discard", int'(i_cnt), 1);
        pkt_sent = 1'b1; tick();
        chk("R10 sent while pending", int'(i_cnt), 0);
        chk("R10 pending through sent", int'(i_kill), 1);
        tick();
        chk("R11 ends empty", int'(i_kill), 0);
        chk("R11 count stays", int'(i_cnt), 0);
    endtask

    task automatic t_kill_empty();
        do_reset();
        tick();
        kill_set = 1'b1; tick();
        chk("R8 kill_busy", int'(i_kill), 1);
        tick();
        chk("R11 finished", int'(i_kill), 0);
        chk("R11 count unchanged", int'(i_cnt), 0);
        chk("R11 busy flag untouched", int'(i_flags[1]), 0);
        chk("R11 kill flag", int'(i_flags[2]), 1);
    endtask

    task automatic t_out();
        do_reset();
        tick();
        chk("R5 empty no fifo_ctl", int'(o_fifo), 0);
        pkt_rcvd = 1'b1; tick();
        chk("R5 received", int'(o_cnt), 1);
        chk("R5 fifo_ctl not yet", int'(o_fifo), 0);
        tick();
        chk("R5 fifo_ctl rises", int'(o_fifo), 1);
        chk("R5 xfer flag", int'(o_flags[0]), 1);
        chk("R12 out rw_allowed", int'(o_rw), 1);
        pkt_rcvd = 1'b1; tick();
        pkt_rcvd = 1'b1; tick();
        chk("R5 all busy", int'(o_cnt), 3);
        chk("R5 bus_bank wraps", int'(o_bus), 0);
        pkt_rcvd = 1'b1; tick();
        chk("R5 full ignores receive", int'(o_cnt), 3);
        chk("R5 bus_bank held", int'(o_bus), 0);
        fifo_rel = 1'b1; tick();
        chk("R5 release frees", int'(o_cnt), 2);
        chk("R5 release drops fifo_ctl", int'(o_fifo), 0);
        chk("R5 sw_bank advance", int'(o_sw), 1);
        tick();
        chk("R5 fifo_ctl again", int'(o_fifo), 1);
    endtask

    task automatic t_ctrl();
        do_reset();
        pkt_rcvd = 1'b1; tick();
        chk("R6 flag on receive", int'(c_flags[0]), 1);
        chk("R6 fifo_ctl zero", int'(c_fifo), 0);
        fifo_rel = 1'b1; kill_set = 1'b1; tick();
        chk("R6 rw_allowed zero", int'(c_rw), 0);
        chk("R6 count zero", int'(c_cnt), 0);
        chk("R8 kill ignored on control", int'(c_kill), 0);
    endtask

    initial begin
        t_reset();
        t_in_flow();
        t_irq();
        t_kill_two();
        t_kill_refused();
        t_kill_empty();
        t_out();
        t_ctrl();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule